// File: doc/BRIEF.md
# Register Command List Processor

This block walks a list of commands held in memory and turns each command into one or more byte-masked register writes. A kick supplies the list's byte address and byte length. The block then reads the list one 32-bit word at a time through a request/response memory port. Each command is a data word followed by a header word. The header names a target register, a 4-bit byte-enable mask, a count of extra data words, and whether a burst steps through consecutive registers or rewrites one register.

Two chained-buffer channels are held inside the block. Their size and address registers are loaded by ordinary writes in the list. A write to a channel's trigger register throws away the rest of the current list and fetching restarts at that channel's buffer. No processor step is needed between buffers. A write to the interrupt register pulses an interrupt output, and the list carries on. Commands always begin on a 64-bit boundary, so a single padding word is skipped when needed.

Top module: `cmdl_proc`

## Requirements
- R1: A header word carries the target register index in bits 15:0, the byte-enable mask in bits 19:16, the extra word count in bits 30:20 and the sequential flag in bit 31. The first register write of a command uses the data word fetched just before the header.
- R2: Byte-enable bit n drives byte lane n of the 32-bit write mask to all ones, and a clear bit drives that lane to zero. For example, 0x5 gives 0x00FF00FF. Every write of a command carries the same mask.
- R3: With the sequential flag set, extra word i (counting from 0) is written to register index + i + 1.
- R4: With the sequential flag clear, every extra word is written to the header's register index.
- R5: Before a command's first word is fetched, the word offset from the list head must be even. If it is odd, one padding word is skipped and is never used as data or header.
- R6: The list ends when the read pointer reaches head + length/4 words. `busy` is high from an accepted kick until the end of the list, and `done` pulses for one cycle right after `busy` falls. Memory requests and writes occur only while busy.
- R7: If a command's header would lie past the list end, or its extra count runs past the list end, processing stops at the end of the list. No write is issued for a word that was not fetched.
- R8: The chained-buffer registers occupy indices 0x238 to 0x23D in this order: channel 0 size, channel 1 size, channel 0 address, channel 1 address, channel 0 trigger, channel 1 trigger. Size and address are counted in units of 8 bytes. Writes to the size and address registers from the list are merged under the byte mask.
- R9: An accepted write to a trigger register (0x23C for channel 0, 0x23D for channel 1) is issued on the write port. It then sets the list head and the read pointer to 8 × address bytes and the length to 8 × size bytes. Fetching continues from the new list, and any remaining words of the current command are dropped.
- R10: An accepted write to register index IRQ_IDX (default 0x010) raises `irq` for exactly one cycle, and processing continues.
- R11: A kick that arrives while busy is ignored.
- R12: While `wr_valid` is high and `wr_ready` is low, the write outputs hold steady. Likewise, a memory request holds its address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kick_valid | input | 1 | Start a list (taken only when idle) |
| kick_addr | input | 32 | List byte address, word aligned |
| kick_len | input | 32 | List length in bytes |
| busy | output | 1 | A list is being processed |
| done | output | 1 | One-cycle pulse after the list ends |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data word |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Register write accepted |
| wr_idx | output | 16 | Target register index |
| wr_data | output | 32 | Write data |
| wr_mask | output | 32 | Byte write mask |
| irq | output | 1 | Interrupt pulse |

## Verification
The first list mixes three kinds of command: a lone write with a full mask, a sequential burst with a checkerboard mask, and a repeat burst with a single-lane mask. The burst ends on an odd offset, so a poisoned padding word tells correct alignment apart from a read of garbage. A padding word also sits at the very end of the list, which checks that padding cannot extend the list. Two short lists end mid-command, so a header or extra word beyond the length would show up as an unexpected write. A chained sequence first programs both channels, one size through a partial byte mask, and then jumps twice with an interrupt write in between. Poisoned words follow every trigger, so a missing jump, a wrong size, or an unmasked size write shows up as a wrong or extra write.

// File: rtl/cmdl_pkg.sv
package cmdl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_REQ,
        ST_WAIT,
        ST_WRITE,
        ST_FIN
    } cmdl_state_e;

    typedef enum logic [1:0] {
        PH_FIRST,
        PH_HDR,
        PH_EXTRA
    } cmdl_phase_e;

    // Packed MSB first: bit 31 seq, 30:20 extra, 19:16 byte enables, 15:0 index
    typedef struct packed {
        logic        seq;
        logic [10:0] extra;
        logic [3:0]  be;
        logic [15:0] idx;
    } cmdl_hdr_t;

endpackage

// File: rtl/cmdl_be_expand.sv
module cmdl_be_expand #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0]   be,
    output logic [8*LANES-1:0] mask
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mask[8*g +: 8] = {8{be[g]}};
    end
endmodule

// File: rtl/cmdl_chain_regs.sv
module cmdl_chain_regs #(
    parameter logic [15:0] BASE   = 16'h0238,
    parameter int          NCH    = 2,
    parameter int          SIZE_W = 20,
    parameter int          ADDR_W = 28,
    localparam int         CHW    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [15:0]           idx,
    input  logic [31:0]           data,
    input  logic [31:0]           mask,
    output logic [NCH*SIZE_W-1:0] size_flat,
    output logic [NCH*ADDR_W-1:0] addr_flat,
    output logic                  trig_hit,
    output logic [CHW-1:0]        trig_ch
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [SIZE_W-1:0] size_q;
        logic [ADDR_W-1:0] addr_q;
        logic [31:0]       size_m, addr_m;

        assign size_m = ({{(32-SIZE_W){1'b0}}, size_q} & ~mask) | (data & mask);
        assign addr_m = ({{(32-ADDR_W){1'b0}}, addr_q} & ~mask) | (data & mask);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                size_q <= '0;
                addr_q <= '0;
            end else if (we) begin
                if (idx == BASE + 16'(c))       size_q <= size_m[SIZE_W-1:0];
                if (idx == BASE + 16'(NCH + c)) addr_q <= addr_m[ADDR_W-1:0];
            end
        end

        assign size_flat[c*SIZE_W +: SIZE_W] = size_q;
        assign addr_flat[c*ADDR_W +: ADDR_W] = addr_q;
    end

    always_comb begin
        trig_hit = 1'b0;
        trig_ch  = '0;
        for (int c = 0; c < NCH; c++) begin
            if (idx == BASE + 16'(2*NCH + c)) begin
                trig_hit = 1'b1;
                trig_ch  = CHW'(c);
            end
        end
    end
endmodule

// File: rtl/cmdl_proc.sv
module cmdl_proc
    import cmdl_pkg::*;
#(
    parameter int          WA         = 30,
    parameter logic [15:0] IRQ_IDX    = 16'h0010,
    parameter logic [15:0] CHAIN_BASE = 16'h0238,
    parameter int          NCH        = 2,
    parameter int          SIZE_W     = 20,
    parameter int          CADDR_W    = 28
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        kick_valid,
    input  logic [31:0] kick_addr,
    input  logic [31:0] kick_len,
    output logic        busy,
    output logic        done,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        wr_valid,
    input  logic        wr_ready,
    output logic [15:0] wr_idx,
    output logic [31:0] wr_data,
    output logic [31:0] wr_mask,
    output logic        irq
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        cmdl_state_e st;
        cmdl_phase_e ph;
        logic [WA-1:0] head;
        logic [WA-1:0] ptr;
        logic [WA-1:0] lim;
        logic [31:0]   data;
        logic [15:0]   idx;
        logic [3:0]    be;
        logic [10:0]   remain;
        logic          seq;
        logic          irq;
        logic          done;
    } regs_t;

    regs_t r_q, r_d;

    logic [NCH*SIZE_W-1:0]  size_flat;
    logic [NCH*CADDR_W-1:0] addr_flat;
    logic                   trig_hit;
    logic [CHW-1:0]         trig_ch;
    logic                   wr_fire;
    logic [SIZE_W-1:0]      sel_size;
    logic [CADDR_W-1:0]     sel_addr;

    assign wr_fire  = (r_q.st == ST_WRITE) && wr_ready;
    assign sel_size = size_flat[trig_ch*SIZE_W +: SIZE_W];
    assign sel_addr = addr_flat[trig_ch*CADDR_W +: CADDR_W];

    cmdl_be_expand #(.LANES(4)) u_be (
        .be   (r_q.be),
        .mask (wr_mask)
    );

    cmdl_chain_regs #(
        .BASE   (CHAIN_BASE),
        .NCH    (NCH),
        .SIZE_W (SIZE_W),
        .ADDR_W (CADDR_W)
    ) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_fire),
        .idx       (r_q.idx),
        .data      (r_q.data),
        .mask      (wr_mask),
        .size_flat (size_flat),
        .addr_flat (addr_flat),
        .trig_hit  (trig_hit),
        .trig_ch   (trig_ch)
    );

    always_comb begin
        logic [WA-1:0] p;
        logic [WA-1:0] new_head;
        cmdl_hdr_t     h;
        r_d      = r_q;
        r_d.irq  = 1'b0;
        r_d.done = 1'b0;
        h        = cmdl_hdr_t'(mem_rsp_data);
        p        = r_q.ptr + WA'(r_q.ptr[0] ^ r_q.head[0]);
        new_head = WA'({sel_addr, 1'b0});
        unique case (r_q.st)
            ST_IDLE: if (kick_valid) begin
                r_d.head = kick_addr[WA+1:2];
                r_d.ptr  = kick_addr[WA+1:2];
                r_d.lim  = kick_addr[WA+1:2] + kick_len[WA+1:2];
                r_d.st   = ST_CMD;
            end
            ST_CMD: begin
                if (p >= r_q.lim) begin
                    r_d.st = ST_FIN;
                end else begin
                    r_d.ptr = p;
                    r_d.ph  = PH_FIRST;
                    r_d.st  = ST_REQ;
                end
            end
            ST_REQ: if (mem_req_ready) begin
                r_d.ptr = r_q.ptr + WA'(1);
                r_d.st  = ST_WAIT;
            end
            ST_WAIT: if (mem_rsp_valid) begin
                unique case (r_q.ph)
                    PH_FIRST: begin
                        r_d.data = mem_rsp_data;
                        r_d.ph   = PH_HDR;
                        r_d.st   = (r_q.ptr >= r_q.lim) ? ST_FIN : ST_REQ;
                    end
                    PH_HDR: begin
                        r_d.idx    = h.idx;
                        r_d.be     = h.be;
                        r_d.remain = h.extra;
                        r_d.seq    = h.seq;
                        r_d.st     = ST_WRITE;
                    end
                    default: begin
                        r_d.data = mem_rsp_data;
                        if (r_q.seq) r_d.idx = r_q.idx + 16'd1;
                        r_d.st   = ST_WRITE;
                    end
                endcase
            end
            ST_WRITE: if (wr_ready) begin
                r_d.irq = (r_q.idx == IRQ_IDX);
                if (trig_hit) begin
                    r_d.head = new_head;
                    r_d.ptr  = new_head;
                    r_d.lim  = new_head + WA'({sel_size, 1'b0});
                    r_d.st   = ST_CMD;
                end else if (r_q.remain == '0) begin
                    r_d.st = ST_CMD;
                end else if (r_q.ptr >= r_q.lim) begin
                    r_d.st = ST_FIN;
                end else begin
                    r_d.remain = r_q.remain - 11'd1;
                    r_d.ph     = PH_EXTRA;
                    r_d.st     = ST_REQ;
                end
            end
            default: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.ph   <= PH_FIRST;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy          = (r_q.st != ST_IDLE);
    assign done          = r_q.done;
    assign irq           = r_q.irq;
    assign mem_req_valid = (r_q.st == ST_REQ);
    assign mem_req_addr  = 32'({r_q.ptr, 2'b00});
    assign wr_valid      = (r_q.st == ST_WRITE);
    assign wr_idx        = r_q.idx;
    assign wr_data       = r_q.data;
endmodule

// File: rtl/cmdl_chk.sv
module cmdl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [15:0] wr_idx,
    input logic [31:0] wr_data,
    input logic [31:0] wr_mask,
    input logic        irq
);
    // R12
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_idx) && $stable(wr_data) && $stable(wr_mask));

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy ##1 !done);

    // R6
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6
    traffic_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || wr_valid) |-> busy);

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R2
    lane_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_mask[7:0] == 8'h00 || wr_mask[7:0] == 8'hFF) &&
                      (wr_mask[15:8] == 8'h00 || wr_mask[15:8] == 8'hFF) &&
                      (wr_mask[23:16] == 8'h00 || wr_mask[23:16] == 8'hFF) &&
                      (wr_mask[31:24] == 8'h00 || wr_mask[31:24] == 8'hFF)));
endmodule

bind cmdl_proc cmdl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .done          (done),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_idx        (wr_idx),
    .wr_data       (wr_data),
    .wr_mask       (wr_mask),
    .irq           (irq)
);

// File: tb/cmdl_proc_bench.sv
module cmdl_proc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        kick_valid = 1'b0;
    logic [31:0] kick_addr = '0;
    logic [31:0] kick_len = '0;
    logic        busy, done;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [15:0] wr_idx;
    logic [31:0] wr_data, wr_mask;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int irq_cnt = 0;
    int cyc = 0;
    bit finished = 0;

    logic [31:0] mem [0:255];
    logic [79:0] exp_q [$];
    bit          pend = 0;
    logic [7:0]  pend_w = '0;

    always #10 clk = ~clk;

    cmdl_proc u_cmdl_proc (
        .clk(clk), .rst_n(rst_n), .kick_valid(kick_valid), .kick_addr(kick_addr),
        .kick_len(kick_len), .busy(busy), .done(done), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_data(wr_data),
        .wr_mask(wr_mask), .irq(irq)
    );

    function automatic logic [31:0] expand(input logic [3:0] be);
        logic [31:0] m = '0;
        for (int k = 0; k < 4; k++) if (be[k]) m = m | (32'hFF << (8*k));
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: lays a command into memory and queues the writes it must produce
    task automatic cmd(input int wp, input logic [15:0] idx, input logic [3:0] be,
                       input bit seq, input int nx, input logic [31:0] base);
        mem[wp]   = base;
        mem[wp+1] = {seq, 11'(nx), be, idx};
        exp_q.push_back({idx, base, expand(be)});
        for (int k = 0; k < nx; k++) begin
            mem[wp+2+k] = base + 32'(k + 1);
            exp_q.push_back({seq ? idx + 16'(k + 1) : idx, base + 32'(k + 1), expand(be)});
        end
    endtask

    // Memory model, ready pattern and write monitor
    always @(negedge clk) begin
        bit r;
        cyc++;
        r = (cyc % 3) != 1;
        wr_ready = r;
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem[pend_w];
            pend = 0;
        end else begin
            mem_rsp_valid = 1'b0;
        end
        if (mem_req_valid && mem_req_ready) begin
            pend   = 1;
            pend_w = mem_req_addr[9:2];
        end
        if (irq) irq_cnt++;
        if (rst_n && wr_valid && r) begin
            if (exp_q.size() == 0) begin
                check(0, "R7/R11 unexpected write", {wr_idx, wr_data, wr_mask}, '0);
            end else begin
                logic [79:0] e;
                e = exp_q.pop_front();
                // R1 R2 R3 R4 R5 R9: written index, data and mask in order
                check({wr_idx, wr_data, wr_mask} == e, "R1-R4 write stream",
                      {wr_idx, wr_data, wr_mask}, e);
            end
        end
    end

    task automatic kick(input int word, input int bytes);
        @(negedge clk);
        kick_addr  = 32'(word * 4);
        kick_len   = 32'(bytes);
        kick_valid = 1'b1;
        @(negedge clk);
        kick_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        bit seen = 0;
        for (int k = 0; k < 3000 && !seen; k++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        check(seen, req, 80'(seen), 80'd1);
        @(negedge clk);
        check(exp_q.size() == 0, req, 80'(exp_q.size()), 80'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 32'hFFF3_FFFF;
        repeat (3) @(negedge clk);
        // R6 reset state
        check(!busy && !done && !wr_valid && !mem_req_valid && !irq, "R6 reset",
              80'({busy, done, wr_valid, mem_req_valid, irq}), 80'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // List A: single, sequential burst, padding, repeat burst, trailing pad (R1-R5)
        cmd(0, 16'h0040, 4'hF, 0, 0, 32'h1000_0001);
        cmd(2, 16'h0050, 4'h5, 1, 3, 32'h2000_0000);
        cmd(8, 16'h0060, 4'h8, 0, 1, 32'h3000_0000);
        mem[20] = 32'h0000_0077;
        mem[21] = {1'b0, 11'd0, 4'hF, 16'h00A0};
        kick(0, 48);
        // R11: kick while busy with a list that would write 0x0A0
        repeat (3) @(negedge clk);
        kick_addr = 32'd80; kick_len = 32'd8; kick_valid = 1'b1;
        @(negedge clk);
        kick_valid = 1'b0;
        wait_done("R6 list A end");
        repeat (10) @(negedge clk);
        check(!busy, "R11 kick while busy ignored", 80'(busy), 80'd0);

        // R7: extra count runs past end
        mem[16] = 32'h0000_0011;
        mem[17] = {1'b1, 11'd3, 4'hF, 16'h0090};
        mem[18] = 32'h0000_0012;
        exp_q.push_back({16'h0090, 32'h0000_0011, 32'hFFFF_FFFF});
        exp_q.push_back({16'h0091, 32'h0000_0012, 32'hFFFF_FFFF});
        kick(16, 12);
        wait_done("R7 truncated burst");

        // R7: header would lie past the end
        kick(20, 4);
        wait_done("R7 header past end");

        // R8 R9 R10: program channels, jump to channel 0, then to channel 1
        cmd(32, 16'h0238, 4'hF, 0, 0, 32'd3);
        cmd(34, 16'h023A, 4'hF, 0, 0, 32'd32);
        cmd(36, 16'h0239, 4'h1, 0, 0, 32'hABCD_EF01);
        cmd(38, 16'h023B, 4'hF, 0, 0, 32'd48);
        cmd(40, 16'h023C, 4'hF, 0, 0, 32'h0000_00C0);
        cmd(64, 16'h0010, 4'hF, 0, 0, 32'h0000_0E0E);
        cmd(66, 16'h0070, 4'h3, 0, 0, 32'h0000_7070);
        cmd(68, 16'h023D, 4'hF, 0, 0, 32'h0000_00C1);
        cmd(96, 16'h0080, 4'hF, 0, 0, 32'h0000_8080);
        irq_cnt = 0;
        kick(32, 56);
        wait_done("R9 chained jump");
        check(irq_cnt == 1, "R10 irq pulse", 80'(irq_cnt), 80'd1);
        check(!busy, "R6 idle after chain", 80'(busy), 80'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule